// File: doc/BRIEF.md
# Polled Character Device Register Port

This block places a single byte-wide I/O device behind two word registers at the top of the processor's address space. Any load or store whose upper sixteen address bits are all ones is claimed by the block, and the block raises a flag so that the surrounding fabric keeps the access away from ordinary memory. Software drives the device by polling. It reads a status word until the ready bit is set, then loads or stores the data word.

The device side pulses a set strobe when a transfer may take place. On an input, that strobe also latches a fresh byte. The ready bit can only be raised by that strobe. A processor access to the data word lowers it again as a side effect: a load consumes the latched byte, and a store emits one byte on the transmit strobe. A data access made while the device is not ready does no harm. It returns the stale byte or drops the write, and it leaves a sticky error mark behind. That mark stays until software reads the status word.

Bus timing is single cycle. A request is taken on one clock edge, and read data with its valid flag appears in the cycle after.

Top module: `io_poll_regs`

## Requirements
- R1: `io_hit` is high in the same cycle, combinationally, exactly when `bus_req` is high and `bus_addr[31:16]` equals 16'hFFFF.
- R2: During and just after reset, `dev_ready`, `bus_rvalid`, `bus_rdata` and `tx_strobe` are all zero, and the error mark is clear.
- R3: A `dev_set` pulse makes `dev_ready` high from the next cycle and captures `dev_byte` as the input byte.
- R4: A read at window offset 0x0 (status) returns, one cycle later with `bus_rvalid` high, a word with the ready bit at bit 0, the error mark at bit 1 and zeros above. Every read inside the window gives `bus_rvalid` for exactly one cycle.
- R5: A read at offset 0x4 (data) while ready returns the input byte zero-extended in bits 7:0, and ready is low from the next cycle.
- R6: A write at offset 0x4 while ready gives a one-cycle `tx_strobe` in the next cycle, with `tx_byte` equal to `bus_wdata[7:0]`, and lowers ready.
- R7: A write at offset 0x0 changes neither the ready bit nor the error mark.
- R8: A data-word access while ready is 0 returns the stale byte on a read or is dropped on a write (no `tx_strobe`), and it sets the error mark. A status read returns the mark and then clears it.
- R9: When `dev_set` arrives in the same cycle as a ready-clearing data access, ready stays high and the new byte is captured. A read in that cycle still returns the previous byte.
- R10: Window accesses to any other offset, or with nonzero `bus_addr[1:0]`, read as zero and change no state.
- R11: Accesses outside the window produce no `bus_rvalid`, no `tx_strobe` and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Processor access request, one cycle per access |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Load response, one cycle after a window read |
| io_hit | output | 1 | Access falls in the I/O window; memory must not respond |
| dev_set | input | 1 | Device pulse: transfer may take place |
| dev_byte | input | 8 | Input byte, captured on dev_set |
| dev_ready | output | 1 | Current ready bit |
| tx_strobe | output | 1 | One-cycle pulse carrying an accepted output byte |
| tx_byte | output | 8 | Output byte, valid with tx_strobe |

## Verification
The hardest case is the collision between the device raising ready and the processor consuming it in the same cycle. A close second is the chain of an unready data access, a stale-byte return and then a status read that clears the error mark. The stimulus walks every access kind against both values of `dev_set` several times over. Because of that walk, each access kind meets both a ready and an unready flag, and also meets a set error mark. A bench-side model of the flag, the error mark and the held byte predicts every response.

// File: rtl/io_poll_pkg.sv
package io_poll_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  // word index of each register inside the window
  localparam int CTRL_IDX = 0;
  localparam int DATA_IDX = 1;
  // status word bit positions (software decodes these)
  localparam int RDY_BIT  = 0;
  localparam int ERR_BIT  = 1;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_poll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 16,
  parameter logic [ADDR_W-WIN_W-1:0] WIN_TAG = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              rd,
  output logic              wr,
  output reg_sel_e          sel
);
  localparam int IDX_W = WIN_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[WIN_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign hit     = req && (addr[ADDR_W-1:WIN_W] == WIN_TAG);
  assign rd      = hit && !we;
  assign wr      = hit && we;

  always_comb begin
    sel = SEL_NONE;
    if (hit && aligned) begin
      if (idx == IDX_W'(CTRL_IDX))      sel = SEL_CTRL;
      else if (idx == IDX_W'(DATA_IDX)) sel = SEL_DATA;
    end
  end

  // R1: nothing is claimed without a request
  a_r1_no_hit_idle: assert property (@(posedge clk) disable iff (rst)
    !req |-> (!hit && sel == SEL_NONE));
  // R10: a register select only exists for a claimed access
  a_r10_sel_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_NONE) |-> hit);
endmodule

// File: rtl/io_status_flag.sv
module io_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic dev_set,
  input  logic data_acc,
  input  logic ctrl_rd,
  output logic ready,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      err   <= 1'b0;
    end else begin
      // device set has priority over the processor side clear
      if (dev_set)       ready <= 1'b1;
      else if (data_acc) ready <= 1'b0;

      if (data_acc && !ready) err <= 1'b1;
      else if (ctrl_rd)       err <= 1'b0;
    end
  end

  // R3 and R9: a device set always leaves ready high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    dev_set |=> ready);
  // R5: consuming access without a set drops ready
  a_r5_clear_on_access: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !dev_set) |=> !ready);
  // R8: unready access leaves the error mark
  a_r8_err_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !ready) |=> err);
  // R7: only a status read removes the mark
  a_r7_err_holds: assert property (@(posedge clk) disable iff (rst)
    (err && !ctrl_rd) |=> err);
  // R3: ready rises only on a device pulse
  a_r3_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    (!ready && !dev_set) |=> !ready);
endmodule

// File: rtl/io_data_path.sv
module io_data_path
  import io_poll_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_set,
  input  logic [BYTE_W-1:0] dev_byte,
  input  logic              rd,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic              ready,
  input  logic              err,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [BYTE_W-1:0] rx_byte;
  logic [DATA_W-1:0] rd_word;
  logic              tx_take;

  assign tx_take = wr && (sel == SEL_DATA) && ready;

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTRL: begin
        rd_word[RDY_BIT] = ready;
        rd_word[ERR_BIT] = err;
      end
      SEL_DATA: rd_word[BYTE_W-1:0] = rx_byte;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte   <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      if (dev_set) rx_byte <= dev_byte;
      rvalid <= rd;
      if (rd) rdata <= rd_word;
      tx_strobe <= tx_take;
      if (tx_take) tx_byte <= wbyte;
    end
  end

  // R4: one response per window read, none otherwise
  a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  a_r11_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
  // R8: a store to an unready port is dropped
  a_r8_drop_write: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_DATA && !ready) |=> !tx_strobe);
  // R6: output byte carries the store data
  a_r6_tx_byte: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> (tx_strobe && tx_byte == $past(wbyte)));
endmodule

// File: rtl/io_poll_regs.sv
module io_poll_regs
  import io_poll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              io_hit,
  input  logic              dev_set,
  input  logic [BYTE_W-1:0] dev_byte,
  output logic              dev_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  logic     rd, wr, ready, err, data_acc, ctrl_rd;
  reg_sel_e sel;
  logic     wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:BYTE_W];
  assign data_acc     = (rd || wr) && (sel == SEL_DATA);
  assign ctrl_rd      = rd && (sel == SEL_CTRL);
  assign dev_ready    = ready;

  io_addr_decode #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W)
  ) u_dec (
    .clk  (clk),
    .rst  (rst),
    .req  (bus_req),
    .we   (bus_we),
    .addr (bus_addr),
    .hit  (io_hit),
    .rd   (rd),
    .wr   (wr),
    .sel  (sel)
  );

  io_status_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .dev_set  (dev_set),
    .data_acc (data_acc),
    .ctrl_rd  (ctrl_rd),
    .ready    (ready),
    .err      (err)
  );

  io_data_path #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .dev_set   (dev_set),
    .dev_byte  (dev_byte),
    .rd        (rd),
    .wr        (wr),
    .sel       (sel),
    .ready     (ready),
    .err       (err),
    .wbyte     (bus_wdata[BYTE_W-1:0]),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );

  // R2: reset leaves the port idle
  a_r2_reset_idle: assert property (@(posedge clk)
    rst |=> (!dev_ready && !bus_rvalid && !tx_strobe));
  // R11: stores outside the window never emit a byte
  a_r11_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !io_hit) |=> !tx_strobe);
endmodule

// File: tb/sim_io_poll_regs.sv
module sim_io_poll_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, io_hit;
  logic        dev_set = 1'b0;
  logic [7:0]  dev_byte = '0;
  logic        dev_ready, tx_strobe;
  logic [7:0]  tx_byte;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic       m_rdy = 0, m_err = 0;
  logic [7:0] m_byte = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_poll_regs u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .io_hit(io_hit), .dev_set(dev_set),
    .dev_byte(dev_byte), .dev_ready(dev_ready), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op: 0 idle, 1 rd status, 2 rd data, 3 wr status, 4 wr data,
  //     5 rd other offset, 6 wr misaligned, 7 rd outside, 8 wr outside
  task automatic access(input int op, input logic ds, input logic [7:0] db,
                        input logic [31:0] wd);
    logic [31:0] a;
    logic        req, we, inwin, isc, isd, rdd, dacc;
    logic [31:0] exp_rd;
    logic        exp_tx;
    string       tag;
    case (op)
      1: a = 32'hFFFF_0000;
      2: a = 32'hFFFF_0004;
      3: a = 32'hFFFF_0000;
      4: a = 32'hFFFF_0004;
      5: a = 32'hFFFF_0008;
      6: a = 32'hFFFF_0006;
      7: a = 32'h0000_0004;
      8: a = 32'hFFFE_0004;
      default: a = 32'h0;
    endcase
    req   = (op != 0);
    we    = (op == 3 || op == 4 || op == 6 || op == 8);
    inwin = req && (a[31:16] == 16'hFFFF);
    isc   = inwin && (a[15:0] == 16'h0000);
    isd   = inwin && (a[15:0] == 16'h0004);
    rdd   = inwin && !we;
    dacc  = isd;
    case (op)
      1: tag = "R4";
      2: tag = m_rdy ? "R5" : "R8";
      3: tag = "R7";
      4: tag = m_rdy ? "R6" : "R8";
      5, 6: tag = "R10";
      7, 8: tag = "R11";
      default: tag = "R3";
    endcase
    if (ds && dacc && m_rdy) tag = "R9";
    exp_rd = '0;
    if (isc) exp_rd = {30'b0, m_err, m_rdy};
    else if (isd) exp_rd = {24'b0, m_byte};
    exp_tx = we && isd && m_rdy;

    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
    dev_set = ds; dev_byte = db;
    #1;
    chk("R1 io_hit", {31'b0, io_hit}, {31'b0, inwin});
    @(posedge clk);
    #1;
    // model update for the edge just taken
    if (dacc && !m_rdy) m_err = 1'b1;
    else if (isc && !we) m_err = 1'b0;
    if (ds) m_rdy = 1'b1;
    else if (dacc) m_rdy = 1'b0;
    if (ds) m_byte = db;

    chk({tag, " rvalid"}, {31'b0, bus_rvalid}, {31'b0, rdd});
    if (rdd) chk({tag, " rdata"}, bus_rdata, exp_rd);
    chk({tag, " tx_strobe"}, {31'b0, tx_strobe}, {31'b0, exp_tx});
    if (exp_tx) chk({tag, " tx_byte"}, {24'b0, tx_byte}, {24'b0, wd[7:0]});
    chk({tag, " dev_ready"}, {31'b0, dev_ready}, {31'b0, m_rdy});
    @(negedge clk);
    bus_req = 0; bus_we = 0; dev_set = 0;
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R2: idle after reset
    chk("R2 dev_ready", {31'b0, dev_ready}, 32'd0);
    chk("R2 rvalid", {31'b0, bus_rvalid}, 32'd0);
    chk("R2 rdata", bus_rdata, 32'd0);
    chk("R2 tx_strobe", {31'b0, tx_strobe}, 32'd0);
    // R2: status reads zero (error mark clear)
    access(1, 1'b0, 8'h00, 32'h0);

    // directed: unready read, sticky error, status read clears it (R8)
    access(2, 1'b0, 8'h00, 32'h0);
    access(4, 1'b0, 8'h00, 32'h0000_00AA);
    access(1, 1'b0, 8'h00, 32'h0);
    access(1, 1'b0, 8'h00, 32'h0);
    // R3 then R9 collision, then R5 consume
    access(0, 1'b1, 8'h3C, 32'h0);
    access(2, 1'b1, 8'hC3, 32'h0);
    access(2, 1'b0, 8'h00, 32'h0);

    // near-exhaustive sweep of access kind against device set
    for (int rep = 0; rep < 4; rep++) begin
      for (int op = 0; op < 9; op++) begin
        for (int ds = 0; ds < 2; ds++) begin
          k++;
          access(op, ds[0] ^ rep[0], 8'(k * 37 + 5),
                 32'hA500_0000 | 32'(k * 91));
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule